// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects interrupt causes for a network interface and presents a single level-sensitive interrupt line to the host. It holds a cause register and a mask register of `DATA_W` bits each. The line `irq_out` is high whenever at least one cause bit is set whose mask bit is also set. The transmit engine, the receive engine, the link monitor and the management port each pulse their own event input for one cycle, and each pulse ORs its bit into the cause register.

The host reaches the block through a simple strobe interface at four word-aligned offsets. A read of the cause offset is destructive: it returns the causes and clears them. The receive-timer cause is the exception. Every receive end-of-packet event is also counted in a saturating pending counter. Each destructive read that finds this counter nonzero sets the receive-timer cause again and takes one off the counter. A host that drains the causes in a loop therefore sees one receive-timer indication per completed packet, even when several packets land between two reads.

The host port has no back-pressure. Every strobe is accepted in the cycle it is presented. A read answers one cycle later with `host_rvalid` high for exactly one cycle. `host_rdata` is zero whenever `host_rvalid` is low.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause register, the mask register and the pending counter are zero, `irq_out` is low, `host_rvalid` is low and `host_rdata` is zero.
- R2: A read strobe (`host_sel`=1, `host_wr`=0) at offset 0x0C0 returns the cause register as it stood before the strobe's clock edge. The answer appears on `host_rdata` with `host_rvalid` high in the cycle after the strobe.
- R3: A read at offset 0x0C0 clears every cause bit at that clock edge, apart from the exceptions in R4 and R10.
- R4: When a cause read occurs while the pending counter is nonzero, cause bit 7 is set again at that edge and the counter is decremented by one.
- R5: A write at offset 0x0C8 ORs `host_wdata` into the cause register. Bits written as 0 are left as they were.
- R6: A write at offset 0x0D0 ORs `host_wdata` into the mask register. A read at offset 0x0D0 returns the mask and does not change it.
- R7: A write at offset 0x0D8 clears every mask bit whose `host_wdata` bit is 1 and leaves the other mask bits as they were.
- R8: `irq_out` equals the OR-reduction of (cause AND mask), taken from the registered state. It therefore follows any cause or mask change in the cycle after the edge that made the change.
- R9: Each event pulse sets its own cause bit: descriptor written back at bit 0, transmit queue empty at bit 1, link status change at bit 2, receive overrun at bit 6, receive end-of-packet at bit 7, management access complete at bit 9.
- R10: An event pulse that arrives in the same cycle as a cause read is kept. Its cause bit is set after that edge.
- R11: Each receive end-of-packet pulse increments the pending counter. The counter saturates at 2^`PEND_W`-1 and never wraps. An increment and a decrement in the same cycle leave it unchanged. With the default width of 4, twenty pulses with no reads in between, followed by back-to-back cause reads, give exactly sixteen reads that show bit 7.
- R12: Reads at the write-only offsets 0x0C8 and 0x0D8, and at any unmapped offset, return zero. Writes at 0x0C0 and at unmapped offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read, qualified by `host_sel` |
| host_addr | input | ADDR_W | Byte offset of the access |
| host_wdata | input | DATA_W | Write data |
| host_rvalid | output | 1 | Read answer valid, the cycle after a read strobe |
| host_rdata | output | DATA_W | Read answer; zero when `host_rvalid` is low |
| evt_desc_done | input | 1 | Transmit descriptor written back pulse |
| evt_txq_empty | input | 1 | Transmit queue empty pulse |
| evt_link_chg | input | 1 | Link status change pulse |
| evt_rx_overrun | input | 1 | Receive overrun pulse |
| evt_rx_eop | input | 1 | Receive end-of-packet pulse |
| evt_mdio_done | input | 1 | Management access complete pulse |
| irq_out | output | 1 | Level interrupt request |

## Verification
The embedded assertions check the local rules on every cycle: event bits survive the edge that follows them, a cause read with no event and no pending packet leaves the register empty, the re-arm of bit 7, OR-only mask sets, and clearing by mask-clear writes. They also check that the counter neither wraps nor moves on a simultaneous increment and decrement, and that `irq_out` stays low under an empty mask. Only the bench scenarios can show that the whole chain holds together. One such scenario is the exact number of receive-timer indications after a burst that saturates the counter. Others are the value a read returns relative to the edge that clears it, the zeros returned from write-only offsets, and the interrupt level tracking a long random mix of sets, clears, reads and events.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word offsets seen by the host
  localparam int unsigned OFS_CAUSE_RD  = 32'h0C0;
  localparam int unsigned OFS_CAUSE_SET = 32'h0C8;
  localparam int unsigned OFS_MASK_SET  = 32'h0D0;
  localparam int unsigned OFS_MASK_CLR  = 32'h0D8;

  // Cause bit positions
  localparam int unsigned BIT_DESC_DONE  = 0;
  localparam int unsigned BIT_TXQ_EMPTY  = 1;
  localparam int unsigned BIT_LINK_CHG   = 2;
  localparam int unsigned BIT_RX_OVERRUN = 6;
  localparam int unsigned BIT_RX_TIMER   = 7;
  localparam int unsigned BIT_MDIO_DONE  = 9;

  localparam int unsigned NUM_EVT = 6;

  // Event index order on the internal event vector
  typedef enum logic [2:0] {
    EV_DESC_DONE  = 3'd0,
    EV_TXQ_EMPTY  = 3'd1,
    EV_LINK_CHG   = 3'd2,
    EV_RX_OVERRUN = 3'd3,
    EV_RX_EOP     = 3'd4,
    EV_MDIO_DONE  = 3'd5
  } evt_idx_e;

  function automatic int unsigned evt_bit_pos(input int unsigned idx);
    case (idx)
      0:       return BIT_DESC_DONE;
      1:       return BIT_TXQ_EMPTY;
      2:       return BIT_LINK_CHG;
      3:       return BIT_RX_OVERRUN;
      4:       return BIT_RX_TIMER;
      default: return BIT_MDIO_DONE;
    endcase
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              rd_any,
  output logic              rd_cause,
  output logic              rd_mask,
  output logic              wr_cause_set,
  output logic              wr_mask_set,
  output logic              wr_mask_clr
);

  logic hit_cause_rd, hit_cause_set, hit_mask_set, hit_mask_clr;

  always_comb begin
    hit_cause_rd  = (host_addr == ADDR_W'(OFS_CAUSE_RD));
    hit_cause_set = (host_addr == ADDR_W'(OFS_CAUSE_SET));
    hit_mask_set  = (host_addr == ADDR_W'(OFS_MASK_SET));
    hit_mask_clr  = (host_addr == ADDR_W'(OFS_MASK_CLR));
  end

  always_comb begin
    rd_any       = host_sel && !host_wr;
    rd_cause     = rd_any && hit_cause_rd;
    rd_mask      = rd_any && hit_mask_set;
    wr_cause_set = host_sel && host_wr && hit_cause_set;
    wr_mask_set  = host_sel && host_wr && hit_mask_set;
    wr_mask_clr  = host_sel && host_wr && hit_mask_clr;
  end

endmodule

// File: rtl/irqc_pend_ctr.sv
module irqc_pend_ctr #(
  parameter int unsigned PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec_req,
  output logic nonzero,
  output logic dec_taken
);

  localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q, cnt_d;

  always_comb begin
    nonzero   = (cnt_q != '0);
    dec_taken = dec_req && nonzero;
    cnt_d     = cnt_q;
    if (inc && !dec_taken && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
    else if (dec_taken && !inc)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && inc && !dec_taken |=> (cnt_q == CNT_MAX)); // R11

  AST_CNT_HOLD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    inc && dec_taken |=> (cnt_q == $past(cnt_q))); // R11

  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_taken && !inc |=> (cnt_q == PEND_W'($past(cnt_q) - 1'b1))); // R4

  AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && !inc |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/irqc_cause_reg.sv
module irqc_cause_reg
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_bits,
  input  logic              rd_clear,
  input  logic              rearm,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_data,
  output logic [DATA_W-1:0] cause
);

  logic [DATA_W-1:0] cause_d;

  always_comb begin
    cause_d = rd_clear ? '0 : cause;
    if (set_we)
      cause_d = cause_d | set_data;
    cause_d = cause_d | evt_bits;
    if (rd_clear && rearm)
      cause_d[BIT_RX_TIMER] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= cause_d;
  end

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bits != '0) |=> ((cause & $past(evt_bits)) == $past(evt_bits))); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && (evt_bits == '0) && !rearm |=> (cause == '0)); // R3

  AST_REARM_RXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && rearm |=> cause[BIT_RX_TIMER]); // R4

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((cause & $past(set_data)) == $past(set_data))); // R5

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear |=> ((cause & $past(cause)) == $past(cause))); // R3

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask
);

  logic [DATA_W-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (set_we)      mask_d = mask | wdata;
    else if (clr_we) mask_d = mask & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask & $past(wdata)) == '0)); // R7

  AST_MASK_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask & ($past(mask) | $past(wdata))) == ($past(mask) | $past(wdata)))); // R6

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we && !clr_we |=> (mask == $past(mask))); // R12

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              evt_desc_done,
  input  logic              evt_txq_empty,
  input  logic              evt_link_chg,
  input  logic              evt_rx_overrun,
  input  logic              evt_rx_eop,
  input  logic              evt_mdio_done,
  output logic              irq_out
);

  logic rd_any, rd_cause, rd_mask, wr_cause_set, wr_mask_set, wr_mask_clr;
  logic pend_nz, pend_dec;
  logic [NUM_EVT-1:0] evt_vec;
  logic [DATA_W-1:0]  evt_bits, cause, mask, rdata_d;

  irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .rd_any       (rd_any),
    .rd_cause     (rd_cause),
    .rd_mask      (rd_mask),
    .wr_cause_set (wr_cause_set),
    .wr_mask_set  (wr_mask_set),
    .wr_mask_clr  (wr_mask_clr)
  );

  always_comb begin
    evt_vec[EV_DESC_DONE]  = evt_desc_done;
    evt_vec[EV_TXQ_EMPTY]  = evt_txq_empty;
    evt_vec[EV_LINK_CHG]   = evt_link_chg;
    evt_vec[EV_RX_OVERRUN] = evt_rx_overrun;
    evt_vec[EV_RX_EOP]     = evt_rx_eop;
    evt_vec[EV_MDIO_DONE]  = evt_mdio_done;
  end

  // Scatter each event onto its cause bit position
  for (genvar g = 0; g < DATA_W; g++) begin : g_evt_map
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int e = 0; e < NUM_EVT; e++)
        if (evt_bit_pos(e) == g) hit = hit | evt_vec[e];
    end
    assign evt_bits[g] = hit;
  end

  irqc_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (evt_rx_eop),
    .dec_req   (rd_cause),
    .nonzero   (pend_nz),
    .dec_taken (pend_dec)
  );

  irqc_cause_reg #(.DATA_W(DATA_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_bits (evt_bits),
    .rd_clear (rd_cause),
    .rearm    (pend_dec),
    .set_we   (wr_cause_set),
    .set_data (host_wdata),
    .cause    (cause)
  );

  irqc_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_mask_set),
    .clr_we (wr_mask_clr),
    .wdata  (host_wdata),
    .mask   (mask)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_cause)     rdata_d = cause;
    else if (rd_mask) rdata_d = mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_any;
      host_rdata  <= rdata_d;
    end
  end

  assign irq_out = |(cause & mask);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_out); // R8

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any && !rd_cause && !rd_mask |=> (host_rdata == '0)); // R12

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> host_rvalid); // R2

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rvalid |-> (host_rdata == '0)); // R2

endmodule

// File: tb/sim_irq_cause_unit.sv
`timescale 1ns/1ps
module sim_irq_cause_unit;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned PW = 4;
  localparam int unsigned PMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rvalid, irq_out;
  logic [DW-1:0] host_rdata;
  logic [5:0] ev = '0; // {mdio, eop, overrun, link, txq, desc}

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] m_cause = '0, m_mask = '0, g_rdata;
  int m_cnt = 0;

  always #2 clk = ~clk;

  irq_cause_unit #(.ADDR_W(AW), .DATA_W(DW), .PEND_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .evt_desc_done(ev[0]), .evt_txq_empty(ev[1]),
    .evt_link_chg(ev[2]), .evt_rx_overrun(ev[3]), .evt_rx_eop(ev[4]),
    .evt_mdio_done(ev[5]), .irq_out(irq_out));

  function automatic logic [DW-1:0] ev_bits(input logic [5:0] e);
    logic [DW-1:0] b = '0;
    b[0] = e[0]; b[1] = e[1]; b[2] = e[2];
    b[6] = e[3]; b[7] = e[4]; b[9] = e[5];
    return b;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle against the reference model
  task automatic step(input logic sel, input logic wr, input logic [AW-1:0] addr,
                      input logic [DW-1:0] wd, input logic [5:0] e);
    logic [DW-1:0] exp_rd, nc, nm;
    int nct;
    logic rd;
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd; ev = e;
    rd = sel && !wr;
    exp_rd = '0;
    if (rd && addr == 16'h0C0) exp_rd = m_cause;
    if (rd && addr == 16'h0D0) exp_rd = m_mask;
    nc = m_cause; nm = m_mask; nct = m_cnt;
    if (rd && addr == 16'h0C0) begin
      nc = '0;
      if (m_cnt != 0) nc[7] = 1'b1;
    end
    if (sel && wr && addr == 16'h0C8) nc = nc | wd;
    if (sel && wr && addr == 16'h0D0) nm = nm | wd;
    if (sel && wr && addr == 16'h0D8) nm = nm & ~wd;
    nc = nc | ev_bits(e);
    begin
      logic dec, inc;
      dec = rd && addr == 16'h0C0 && m_cnt != 0;
      inc = e[4];
      if (inc && !dec && m_cnt < PMAX) nct = m_cnt + 1;
      else if (dec && !inc) nct = m_cnt - 1;
    end
    @(posedge clk);
    #1;
    m_cause = nc; m_mask = nm; m_cnt = nct;
    host_sel = 1'b0; ev = '0;
    g_rdata = host_rdata;
    chk("R8 irq level", {31'b0, irq_out}, {31'b0, |(m_cause & m_mask)});
    chk("R2 rvalid", {31'b0, host_rvalid}, {31'b0, rd});
    if (rd) begin
      if (addr == 16'h0C0)      chk("R2 cause read", host_rdata, exp_rd);
      else if (addr == 16'h0D0) chk("R6 mask read", host_rdata, exp_rd);
      else                      chk("R12 write-only read", host_rdata, exp_rd);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a);  step(1'b1, 1'b0, a, '0, '0); endtask
  task automatic wrt(input logic [AW-1:0] a, input logic [DW-1:0] d); step(1'b1, 1'b1, a, d, '0); endtask
  task automatic evt(input logic [5:0] e); step(1'b0, 1'b0, '0, '0, e); endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
    chk("R1 rvalid after reset", {31'b0, host_rvalid}, 32'd0);
    chk("R1 rdata after reset", host_rdata, 32'd0);
    rd(16'h0C0); chk("R1 cause zero", g_rdata, 32'd0);
    rd(16'h0D0); chk("R1 mask zero", g_rdata, 32'd0);

    // R5 / R3: set, read, then cleared
    wrt(16'h0C8, 32'h0000_0A05);
    wrt(16'h0C8, 32'h0010_0000);
    rd(16'h0C0); chk("R5 cause OR", g_rdata, 32'h0010_0A05);
    rd(16'h0C0); chk("R3 cleared by read", g_rdata, 32'd0);

    // R6 / R7 / R8
    wrt(16'h0D0, 32'h0000_0003);
    wrt(16'h0D0, 32'h0000_0080);
    rd(16'h0D0); chk("R6 mask OR", g_rdata, 32'h0000_0083);
    wrt(16'h0C8, 32'h0000_0002);
    chk("R8 irq set by unmasked cause", {31'b0, irq_out}, 32'd1);
    wrt(16'h0D8, 32'h0000_0002);
    chk("R8 irq dropped by mask clear", {31'b0, irq_out}, 32'd0);
    rd(16'h0D0); chk("R7 mask clear", g_rdata, 32'h0000_0081);
    rd(16'h0C0);

    // R9 bit positions
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] exp;
      exp = ev_bits(6'(1 << i));
      evt(6'(1 << i));
      rd(16'h0C0);
      if (i == 4) exp = 32'h80;
      chk("R9 event position", g_rdata, exp);
      if (i == 4) begin rd(16'h0C0); rd(16'h0C0); end
    end

    // R10 event during read is kept
    wrt(16'h0C8, 32'h0000_0001);
    step(1'b1, 1'b0, 16'h0C0, '0, 6'b000100);
    chk("R10 read returns old causes", g_rdata, 32'h0000_0001);
    rd(16'h0C0); chk("R10 event kept after read", g_rdata, 32'h0000_0004);

    // R11 / R4 saturation: 20 eops then count reads showing bit 7
    repeat (20) evt(6'b010000);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        rd(16'h0C0);
        if (g_rdata[7]) seen++;
      end
      chk("R11 saturated pending reads", 32'(seen), 32'd16);
    end
    // R11 simultaneous inc and dec
    repeat (3) evt(6'b010000);
    step(1'b1, 1'b0, 16'h0C0, '0, 6'b010000);
    begin
      int seen = 0;
      for (int k = 0; k < 8; k++) begin
        rd(16'h0C0);
        if (g_rdata[7]) seen++;
      end
      chk("R11 inc and dec same cycle", 32'(seen), 32'd4);
    end

    // R12 write-only reads and ignored writes
    wrt(16'h0C8, 32'h0000_0040);
    rd(16'h0C8); chk("R12 read of cause-set offset", g_rdata, 32'd0);
    rd(16'h0D8); chk("R12 read of mask-clear offset", g_rdata, 32'd0);
    wrt(16'h0C0, 32'hFFFF_FFFF);
    wrt(16'h0E4, 32'hFFFF_FFFF);
    rd(16'h0D0); chk("R12 mask untouched", g_rdata, 32'h0000_0081);
    rd(16'h0C0); chk("R12 cause untouched", g_rdata, 32'h0000_0040);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [5:0] e;
      logic [DW-1:0] d;
      op = int'($urandom % 8);
      e = 6'($urandom & $urandom);
      d = $urandom & $urandom & $urandom;
      case (op)
        0: step(1'b0, 1'b0, '0, '0, e);
        1, 2: step(1'b1, 1'b0, 16'h0C0, '0, e);
        3: step(1'b1, 1'b1, 16'h0C8, d, e);
        4: step(1'b1, 1'b1, 16'h0D0, d, e);
        5: step(1'b1, 1'b1, 16'h0D8, d, e);
        6: step(1'b1, 1'b0, 16'h0D0, '0, e);
        default: step(1'b1, ($urandom % 2) == 1, 16'h0D8, d, e);
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule